// File: doc/BRIEF.md
# Receive Frame Deframer and Checker

The block sits between a bit decoder and a receive byte FIFO. The decoder supplies one data bit per strobe, along with single-cycle markers that open and close a frame. The block groups the bits into bytes. When the selected protocol carries a parity bit, it checks each byte's parity. It runs a CRC-16 over every byte of the frame. The frame markers, the parity bits and the two trailing CRC bytes are removed, and only payload bytes are written into the FIFO through a valid/ready port.

The CRC trailer cannot be recognised until the frame closes. For that reason the two newest bytes always wait in a short delay line. A byte goes to the FIFO only after two more bytes have completed behind it. The bytes still waiting when the frame closes are the CRC, and they are discarded. Status appears as sticky flags: reception started, clean end of frame, and the three error causes (framing, parity, CRC). A single-cycle interrupt pulse marks every frame close. A clear strobe, issued when software reads the status, empties the flags.

Top module: `rx_deframer`

## Requirements
- R1: Bit strobes and end markers that arrive while no frame is open have no effect. A start marker clears any partly built byte, the CRC register and the waiting bytes, opens a frame and sets `stat_rx_start`.
- R2: Bits are collected least significant bit first. With `par_en` low, a byte is complete after 8 bits.
- R3: With `par_en` high, a 9th bit follows the 8 data bits and is an odd parity bit, so the number of ones across the 9 bits must be odd. The parity bit is never forwarded. A mismatch sets `stat_err_parity`, and the data byte is still handled normally.
- R4: The CRC starts at 0xFFFF and processes each byte's data bits LSB first with the reflected polynomial 0x8408, over payload and trailer alike. The trailer is the complement of the payload CRC, sent low byte first. At the end of a frame with no framing error, a register value other than 0xF0B8 sets `stat_err_crc`.
- R5: Payload bytes reach `out_data` in arrival order. A byte is released in the cycle after the second byte behind it completes. The last two whole bytes of a frame are never released.
- R6: An end marker that arrives while a byte is only partly collected sets `stat_err_frame`, and no CRC error is reported for that frame.
- R7: An end marker after fewer than two whole bytes sets `stat_err_frame`. A frame that contains only the two trailer bytes is valid and releases nothing.
- R8: An end marker sets `stat_eof_ok` when the frame had no framing, parity or CRC error.
- R9: `irq_pulse` is high for exactly one cycle, in the cycle after each end marker that closes an open frame.
- R10: Status flags stay set until `stat_clear` is pulsed. If a flag is set and cleared in the same cycle, the set wins.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_en | input | 1 | Protocol uses a per-byte odd parity bit |
| bit_valid | input | 1 | Strobe: `bit_data` carries a decoded bit |
| bit_data | input | 1 | Decoded bit |
| frame_start | input | 1 | Start-of-frame marker pulse |
| frame_end | input | 1 | End-of-frame marker pulse |
| out_valid | output | 1 | Payload byte available to the FIFO |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | FIFO accepts the byte |
| irq_pulse | output | 1 | One-cycle pulse at each frame close |
| stat_rx_start | output | 1 | Sticky: a frame was opened |
| stat_eof_ok | output | 1 | Sticky: a frame closed cleanly |
| stat_err_frame | output | 1 | Sticky: partial byte or short frame |
| stat_err_parity | output | 1 | Sticky: parity mismatch |
| stat_err_crc | output | 1 | Sticky: CRC residue mismatch |
| stat_clear | input | 1 | Status read: clears the sticky flags |

## Verification
The main function is driven with several frame patterns. Clean multi-byte payloads with and without parity expose bit order and the release delay. A frame with a single bad parity bit shows that the byte is still forwarded and that only the parity flag is raised. A corrupted trailer separates a CRC error from a framing error. Frames that close on a partial byte, after only one byte, after only the trailer, or that are restarted midway probe the edges of the hold-back and the framing checks. Stray bits and end markers sent outside a frame confirm that they are ignored. A periodic `out_ready` stall exercises output holding.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  // One byte through a reflected CRC, data bits taken LSB first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                               input logic [BYTE_W-1:0] d,
                                               input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

  // Odd parity holds when the xor of data plus parity bit is one.
  function automatic logic odd_ok(input logic [BYTE_W:0] w);
    return ^w;
  endfunction
endpackage

// File: rtl/rxd_bit_asm.sv
module rxd_bit_asm
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              par_en,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              par_bad,
  output logic              partial
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int IDX_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] data_q;
  logic [CNT_W-1:0]  last_idx;

  assign last_idx = par_en ? CNT_W'(BYTE_W) : CNT_W'(BYTE_W - 1);

  always_comb begin
    byte_done = bit_en && (cnt_q == last_idx);
    byte_val  = data_q;
    if (!par_en) byte_val[BYTE_W-1] = bit_in;
    par_bad   = byte_done && par_en && !odd_ok({bit_in, data_q});
    partial   = (cnt_q != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else if (bit_en) begin
      cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
      if (cnt_q < CNT_W'(BYTE_W)) data_q[cnt_q[IDX_W-1:0]] <= bit_in;
    end
  end

  AST_BIT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !byte_done && !clr) |=> partial);  // R2
endmodule

// File: rtl/rxd_crc.sv
module rxd_crc
  import rxd_pkg::*;
#(
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF,
  parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc_q <= INIT;
    else if (en)       crc_q <= crc_step(crc_q, din, POLY);
  end
endmodule

// File: rtl/rxd_hold.sv
module rxd_hold
  import rxd_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [BYTE_W-1:0] din,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] stg [DEPTH];
  logic [CW-1:0]     cnt_q;
  logic              release_now;

  assign full        = (cnt_q == CW'(DEPTH));
  assign release_now = push && full && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n)   stg[0] <= '0;
    else if (push) stg[0] <= din;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)    stg[k] <= '0;
      else if (push) stg[k] <= stg[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)    cnt_q <= '0;
    else if (push && !full) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (release_now) begin
      out_valid <= 1'b1;
      out_data  <= stg[DEPTH-1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R11
  AST_RELEASE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> !(out_valid && !$past(out_valid)));  // R5
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import rxd_pkg::*;
#(
  parameter int               TRAIL_BYTES = 2,
  parameter logic [CRC_W-1:0] CRC_INIT    = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_POLY    = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_GOOD    = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_en,
  input  logic              bit_valid,
  input  logic              bit_data,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic              irq_pulse,
  output logic              stat_rx_start,
  output logic              stat_eof_ok,
  output logic              stat_err_frame,
  output logic              stat_err_parity,
  output logic              stat_err_crc,
  input  logic              stat_clear
);
  logic              in_frame_q, frame_par_q;
  logic              bit_en, byte_done, par_bad, partial, hold_full;
  logic [BYTE_W-1:0] byte_val;
  logic [CRC_W-1:0]  crc_q;

  // Named internal events
  logic evt_start, evt_end, evt_err_frame, evt_err_crc, evt_ok;

  assign evt_start     = frame_start;
  assign evt_end       = frame_end && in_frame_q && !frame_start;
  assign bit_en        = bit_valid && in_frame_q && !frame_start && !frame_end;
  assign evt_err_frame = evt_end && (partial || !hold_full);
  assign evt_err_crc   = evt_end && !evt_err_frame && (crc_q != CRC_GOOD);
  assign evt_ok        = evt_end && !evt_err_frame && !evt_err_crc && !frame_par_q;

  rxd_bit_asm u_asm (
    .clk(clk), .rst_n(rst_n), .clr(evt_start || evt_end), .par_en(par_en),
    .bit_en(bit_en), .bit_in(bit_data), .byte_done(byte_done),
    .byte_val(byte_val), .par_bad(par_bad), .partial(partial)
  );

  rxd_crc #(.INIT(CRC_INIT), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(evt_start), .en(byte_done),
    .din(byte_val), .crc_q(crc_q)
  );

  rxd_hold #(.DEPTH(TRAIL_BYTES)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(evt_start || evt_end), .push(byte_done),
    .din(byte_val), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .full(hold_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q  <= 1'b0;
      frame_par_q <= 1'b0;
      irq_pulse   <= 1'b0;
    end else begin
      irq_pulse <= evt_end;
      if (evt_start) begin
        in_frame_q  <= 1'b1;
        frame_par_q <= 1'b0;
      end else if (evt_end) begin
        in_frame_q  <= 1'b0;
      end else if (par_bad) begin
        frame_par_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_rx_start   <= 1'b0;
      stat_eof_ok     <= 1'b0;
      stat_err_frame  <= 1'b0;
      stat_err_parity <= 1'b0;
      stat_err_crc    <= 1'b0;
    end else begin
      stat_rx_start   <= (stat_rx_start   && !stat_clear) || evt_start;
      stat_eof_ok     <= (stat_eof_ok     && !stat_clear) || evt_ok;
      stat_err_frame  <= (stat_err_frame  && !stat_clear) || evt_err_frame;
      stat_err_parity <= (stat_err_parity && !stat_clear) || par_bad;
      stat_err_crc    <= (stat_err_crc    && !stat_clear) || evt_err_crc;
    end
  end

  AST_START_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> stat_rx_start);  // R1
  AST_PAR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_err_parity) |-> $past(par_en));  // R3
  AST_CRC_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_err_crc) |-> $past(frame_end));  // R4
  AST_FRAME_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_err_frame) |-> $past(frame_end));  // R6
  AST_IRQ_FROM_END: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(frame_end));  // R9
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);  // R9
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clear && !frame_start) |=> !stat_rx_start);  // R10
endmodule

// File: tb/test_rx_deframer.sv
`timescale 1ns/1ps
module test_rx_deframer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_en = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
  logic       frame_start = 1'b0, frame_end = 1'b0, out_ready = 1'b1, stat_clear = 1'b0;
  logic       out_valid, irq_pulse;
  logic [7:0] out_data;
  logic       stat_rx_start, stat_eof_ok, stat_err_frame, stat_err_parity, stat_err_crc;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  logic [7:0] tx[$];

  always #4 clk = ~clk;

  rx_deframer i_rx_deframer (
    .clk(clk), .rst_n(rst_n), .par_en(par_en), .bit_valid(bit_valid), .bit_data(bit_data),
    .frame_start(frame_start), .frame_end(frame_end), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .irq_pulse(irq_pulse),
    .stat_rx_start(stat_rx_start), .stat_eof_ok(stat_eof_ok),
    .stat_err_frame(stat_err_frame), .stat_err_parity(stat_err_parity),
    .stat_err_crc(stat_err_crc), .stat_clear(stat_clear)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Reference CRC: bitwise, per the stated polynomial and seed
  function automatic logic [15:0] ref_crc(input logic [7:0] bytes[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (bytes[i])
      for (int b = 0; b < 8; b++)
        c = ((c ^ {15'd0, bytes[i][b]}) & 16'h1) != 0 ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  // out_ready: one stalled cycle in five
  always @(posedge clk) begin
    cyc++;
    #1 out_ready = ((cyc % 5) != 3);
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R5", "unexpected output byte", out_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R2/R5", "payload byte", out_data, e);
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk); bit_valid = 1'b1; bit_data = b;
    @(negedge clk); bit_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit par, input bit bad);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    if (par) send_bit(bad ? ^v : ~^v);
  endtask

  task automatic pulse_start();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    chk(stat_rx_start == 1'b1, "R1", "start flag", stat_rx_start, 1);
  endtask

  task automatic pulse_end(input bit expect_irq);
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    chk(irq_pulse == expect_irq, "R9", "irq at close", irq_pulse, expect_irq);
    @(negedge clk);
    chk(irq_pulse == 1'b0, "R9", "irq one cycle", irq_pulse, 0);
  endtask

  task automatic clear_flags();
    @(negedge clk); stat_clear = 1'b1;
    @(negedge clk); stat_clear = 1'b0;
  endtask

  // Sends tx (+ CRC trailer unless no_crc); queues bytes that must be released
  task automatic send_frame(input bit par, input int bad_idx, input bit flip_crc,
                            input bit no_crc, input int extra_bits);
    logic [7:0] all[$];
    logic [15:0] c;
    all = tx;
    if (!no_crc) begin
      c = ~ref_crc(tx);
      if (flip_crc) c[0] = ~c[0];
      all.push_back(c[7:0]);
      all.push_back(c[15:8]);
    end
    par_en = par;
    pulse_start();
    for (int i = 0; i < all.size(); i++) begin
      if (i + 2 < all.size()) exp_q.push_back(all[i]);
      send_byte(all[i], par, i == bad_idx);
    end
    for (int i = 0; i < extra_bits; i++) send_bit(1'b1);
    pulse_end(1'b1);
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all payload delivered", exp_q.size(), 0);
  endtask

  task automatic chk_flags(input string req, input logic [3:0] e);
    chk({stat_eof_ok, stat_err_frame, stat_err_parity, stat_err_crc} == e, req,
        "flags ok/frame/par/crc",
        {stat_eof_ok, stat_err_frame, stat_err_parity, stat_err_crc}, e);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R1)
    chk({out_valid, irq_pulse, stat_rx_start} == 3'b0, "R1", "reset outputs",
        {out_valid, irq_pulse, stat_rx_start}, 0);
    chk_flags("R1", 4'b0000);

    // Stray activity outside a frame is ignored (R1)
    for (int i = 0; i < 12; i++) send_bit(i[0]);
    pulse_end(1'b0);
    chk(out_valid == 1'b0, "R1", "no output outside frame", out_valid, 0);
    chk(stat_rx_start == 1'b0, "R1", "no start flag outside frame", stat_rx_start, 0);
    chk_flags("R1", 4'b0000);

    // Clean frame, no parity (R2 R4 R5 R8)
    tx = '{8'h11, 8'hA5, 8'h3C, 8'h80, 8'hFF};
    send_frame(0, -1, 0, 0, 0);
    chk_flags("R8", 4'b1000);

    // Sticky, then clear (R10)
    repeat (20) @(negedge clk);
    chk(stat_eof_ok == 1'b1, "R10", "flag stays set", stat_eof_ok, 1);
    clear_flags();
    chk_flags("R10", 4'b0000);
    chk(stat_rx_start == 1'b0, "R10", "start flag cleared", stat_rx_start, 0);

    // Clean frame with parity (R3)
    tx = '{8'h01, 8'hFE, 8'h77};
    send_frame(1, -1, 0, 0, 0);
    chk_flags("R3", 4'b1000);
    clear_flags();

    // One bad parity bit: byte still forwarded, only parity flagged (R3)
    tx = '{8'h22, 8'h33, 8'h44};
    send_frame(1, 1, 0, 0, 0);
    chk_flags("R3", 4'b0010);
    clear_flags();

    // Corrupted trailer (R4)
    tx = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
    send_frame(0, -1, 1, 0, 0);
    chk_flags("R4", 4'b0001);
    clear_flags();

    // Close on a partial byte (R6)
    tx = '{8'h5A, 8'hC3};
    send_frame(0, -1, 0, 0, 3);
    chk_flags("R6", 4'b0100);
    clear_flags();

    // Only one whole byte (R7)
    tx = '{8'h5A};
    send_frame(0, -1, 0, 1, 0);
    chk_flags("R7", 4'b0100);
    clear_flags();

    // Trailer only: valid, nothing released (R7)
    tx = '{};
    send_frame(0, -1, 0, 0, 0);
    chk_flags("R7", 4'b1000);
    clear_flags();

    // Restart mid-frame: first bytes are dropped (R1)
    par_en = 1'b0;
    pulse_start();
    send_byte(8'h99, 0, 0);
    send_byte(8'h66, 0, 0);
    tx = '{8'h12, 8'h34, 8'h56};
    send_frame(0, -1, 0, 0, 0);
    chk_flags("R1", 4'b1000);

    // Set wins over clear in the same cycle (R10)
    clear_flags();
    @(negedge clk); frame_start = 1'b1; stat_clear = 1'b1;
    @(negedge clk); frame_start = 1'b0; stat_clear = 1'b0;
    chk(stat_rx_start == 1'b1, "R10", "set beats clear", stat_rx_start, 1);
    pulse_end(1'b1);
    chk_flags("R7", 4'b0100);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule